// File: doc/BRIEF.md
# Radix-4 Sequential Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and produces the full `2*WIDTH`-bit product over several clock cycles. It consumes the multiplier two bits at a time. Each two-bit group, taken from the least significant end, selects zero, the multiplicand, twice the multiplicand, or a stored three-times multiple. The selected value is added into the upper half of a running partial product, and the whole partial product then moves right by two places. After `WIDTH/2` such steps the partial product holds the exact result.

The block is driven through a start/busy/done handshake. A caller presents both operands with a one-cycle `start` while the block is not busy. The block spends one cycle forming the three-times multiple, then `WIDTH/2` cycles stepping through the digits. It then raises `done` for one cycle with the product on its output. The product stays there until the next accepted start. `WIDTH` must be even and at least 4.

Top module: `radix4_mult`

## Requirements
- R1: While `rstN` is low, `busy`, `done` and `product` are all zero.
- R2: A `start` sampled high on a clock edge while `busy` is low launches a multiplication, captures `opA` and `opB` on that edge, and makes `busy` high in the following cycle.
- R3: Counting the launch edge as edge 0, `busy` stays high until edge `WIDTH/2+1`. After that edge `busy` is low and `done` is high for exactly one cycle. `busy` and `done` are never high together.
- R4: In the `done` cycle, `product` equals the unsigned product `opA*opB` of the operands captured at launch, including the case where both operands are all ones.
- R5: A `start` sampled while `busy` is high has no effect: the operands, the latency and the result of the multiplication in progress do not change.
- R6: While `busy` is low, `product` holds its value until the next accepted start. The edge that accepts a start clears `product` to zero.
- R7: Each two-bit multiplier group with value 0, 1, 2 or 3 contributes 0, 1, 2 or 3 times the multiplicand at its weight. Multipliers made only of 01, only of 10, only of 11, or of all four group values each give the exact product.
- R8: A new start sampled in the `done` cycle is accepted, so back-to-back operations lose no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled while not busy |
| opA | input | WIDTH | Multiplicand, unsigned |
| opB | input | WIDTH | Multiplier, unsigned |
| busy | output | 1 | High while the multiple is formed and the digits are stepped |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2*WIDTH | Result; meaningful while busy is low |

## Verification
Random operand pairs exercise the carry paths in general. All-ones operands push the high part plus the three-times multiple to its largest sum, so an adder that is too narrow shows up there. Multipliers built only from 01, only from 10 and only from 11 groups each select a single multiple, so a wrong multiple or a swapped selection shows up in isolation. A mixed 3-2-1-0 pattern confirms the digit order. Starts pulsed during a run, starts in the done cycle and idle gaps between runs separate the ignore rule, the back-to-back rule and the hold rule.

// File: rtl/radix4_mult_pkg.sv
package radix4_mult_pkg;

  // Sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } mulState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOps;     // capture operands, clear partial product
    logic loadTriple;  // register 3x multiple
    logic stepEn;      // retire one radix-4 digit
  } mulCtrl_t;

endpackage

// File: rtl/radix4_mult_ctrl.sv
module radix4_mult_ctrl
  import radix4_mult_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output mulCtrl_t ctrl,
  output logic     busy,
  output logic     done
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

  mulState_e stateQ, stateD;
  logic [CW-1:0] stepCntQ, stepCntD;
  logic acceptStart;

  // A start is taken only when no operation is in flight
  assign acceptStart = start && ((stateQ == ST_IDLE) || (stateQ == ST_FIN));

  always_comb begin
    stateD          = stateQ;
    stepCntD        = stepCntQ;
    ctrl.loadOps    = 1'b0;
    ctrl.loadTriple = 1'b0;
    ctrl.stepEn     = 1'b0;
    unique case (stateQ)
      ST_IDLE, ST_FIN: begin
        if (acceptStart) begin
          ctrl.loadOps = 1'b1;
          stateD       = ST_PREP;
        end else begin
          stateD = ST_IDLE;
        end
      end
      ST_PREP: begin
        ctrl.loadTriple = 1'b1;
        stepCntD        = '0;
        stateD          = ST_RUN;
      end
      ST_RUN: begin
        ctrl.stepEn = 1'b1;
        if (stepCntQ == LAST_STEP) begin
          stateD = ST_FIN;
        end else begin
          stepCntD = stepCntQ + 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      stepCntQ <= '0;
    end else begin
      stateQ   <= stateD;
      stepCntQ <= stepCntD;
    end
  end

  assign busy = (stateQ == ST_PREP) || (stateQ == ST_RUN);
  assign done = (stateQ == ST_FIN);

endmodule

// File: rtl/radix4_mult_digit_sel.sv
module radix4_mult_digit_sel #(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       digit,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH+1:0] triple,
  output logic [WIDTH+1:0] multiple
);

  // Digit value picks 0, x, 2x or the stored 3x
  always_comb begin
    unique case (digit)
      2'd0:    multiple = '0;
      2'd1:    multiple = {2'b00, mcand};
      2'd2:    multiple = {1'b0, mcand, 1'b0};
      default: multiple = triple;
    endcase
  end

endmodule

// File: rtl/radix4_mult_datapath.sv
module radix4_mult_datapath
  import radix4_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulCtrl_t           ctrl,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);

  localparam int SUM_W = WIDTH + 2;

  logic [WIDTH-1:0] mcandQ;
  logic [WIDTH-1:0] mplierQ;
  logic [SUM_W-1:0] tripleQ;
  logic [WIDTH-1:0] hiAccQ;
  logic [WIDTH-1:0] loAccQ;
  logic [SUM_W-1:0] multiple;
  logic [SUM_W-1:0] stepSum;

  radix4_mult_digit_sel #(.WIDTH(WIDTH)) u_digitSel (
    .digit    (mplierQ[1:0]),
    .mcand    (mcandQ),
    .triple   (tripleQ),
    .multiple (multiple)
  );

  // Two extra bits keep high part + 3x from overflowing
  assign stepSum = {2'b00, hiAccQ} + multiple;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandQ  <= '0;
      mplierQ <= '0;
      tripleQ <= '0;
      hiAccQ  <= '0;
      loAccQ  <= '0;
    end else begin
      if (ctrl.loadOps) begin
        mcandQ  <= opA;
        mplierQ <= opB;
        hiAccQ  <= '0;
        loAccQ  <= '0;
      end
      if (ctrl.loadTriple) begin
        tripleQ <= {2'b00, mcandQ} + {1'b0, mcandQ, 1'b0};
      end
      if (ctrl.stepEn) begin
        hiAccQ  <= stepSum[SUM_W-1:2];
        loAccQ  <= {stepSum[1:0], loAccQ[WIDTH-1:2]};
        mplierQ <= {2'b00, mplierQ[WIDTH-1:2]};
      end
    end
  end

  assign product = {hiAccQ, loAccQ};

endmodule

// File: rtl/radix4_mult.sv
module radix4_mult
  import radix4_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  localparam int STEPS = WIDTH / 2;

  mulCtrl_t ctrl;

  radix4_mult_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  radix4_mult_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );

endmodule

// File: rtl/radix4_mult_checker.sv
module radix4_mult_checker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  localparam int STEPS = WIDTH / 2;
  localparam logic [15:0] DONE_AT = 16'(STEPS + 2);

  logic [WIDTH-1:0] capA, capB;
  logic [15:0]      cycCnt;
  logic             launch;

  assign launch = start && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capA   <= '0;
      capB   <= '0;
      cycCnt <= '0;
    end else if (launch) begin
      capA   <= opA;
      capB   <= opB;
      cycCnt <= 16'd1;
    end else if (busy) begin
      cycCnt <= cycCnt + 16'd1;
    end
  end

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> busy); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R3

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycCnt == DONE_AT)); // R3

  AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == ({{WIDTH{1'b0}}, capA} * {{WIDTH{1'b0}}, capB}))); // R4

  AST_STILL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && (cycCnt < DONE_AT - 16'd1)) |=> busy); // R5

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product)); // R6

  AST_LAUNCH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> (product == '0)); // R6

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> busy); // R8

endmodule

bind radix4_mult radix4_mult_checker #(.WIDTH(WIDTH)) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opA     (opA),
  .opB     (opB),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/radix4_mult_bench.sv
module radix4_mult_bench;

  localparam int W = 8;
  localparam int W2 = 2 * W;
  localparam int STEPS = W / 2;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 200000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic          busy;
  logic          done;
  logic [W2-1:0] product;

  int errors = 0;
  int checks = 0;
  bit cmpEn = 1'b0;
  int cycles = 0;

  radix4_mult #(.WIDTH(W)) u_radix4_mult (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opA     (opA),
    .opB     (opB),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [W2-1:0] act, input logic [W2-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  bit            mBusy = 1'b0;
  bit            mDone = 1'b0;
  int            mRemain = 0;
  logic [W2-1:0] mProd = '0;
  logic [W2-1:0] mPend = '0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 1'b0; mDone = 1'b0; mRemain = 0; mProd = '0; mPend = '0;
    end else if (!mBusy && start) begin
      mBusy = 1'b1; mDone = 1'b0; mRemain = STEPS + 1;
      mPend = W2'(opA) * W2'(opB);
      mProd = '0;
    end else if (mBusy) begin
      mRemain--;
      if (mRemain == 0) begin
        mBusy = 1'b0; mDone = 1'b1; mProd = mPend;
      end
    end else begin
      mDone = 1'b0;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmpEn && rstN) begin
      check(busy == mBusy, "R3 busy", W2'(busy), W2'(mBusy));
      check(done == mDone, "R3 done", W2'(done), W2'(mDone));
      if (!mBusy) check(product == mProd, mDone ? "R4" : "R6", product, mProd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      errors++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Called at a falling edge; returns at the falling edge of the done cycle
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [W2-1:0] exp;
    exp = W2'(a) * W2'(b);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", W2'(busy), W2'(1));
    while (!done) @(negedge clk);
    check(product == exp, tag, product, exp);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    check(busy == 1'b0, "R1", W2'(busy), '0);
    check(done == 1'b0, "R1", W2'(done), '0);
    check(product == '0, "R1", product, '0);
    rstN = 1'b1;
    cmpEn = 1'b1;
    @(negedge clk);

    // R4: corner operands
    runOp('1, '1, "R4 all-ones");
    @(negedge clk);
    runOp('0, '1, "R4 zero");
    @(negedge clk);
    runOp('1, W'(1), "R4 one");
    @(negedge clk);

    // R7: single-digit and mixed patterns
    runOp('1, {(W/2){2'b01}}, "R7 digits 1");
    @(negedge clk);
    runOp('1, {(W/2){2'b10}}, "R7 digits 2");
    @(negedge clk);
    runOp(W'(8'hB7), {(W/2){2'b11}}, "R7 digits 3");
    @(negedge clk);
    runOp(W'(8'hC9), W'(8'hE4), "R7 mixed 3210");
    @(negedge clk);

    // R5: starts during a run are ignored
    begin
      logic [W2-1:0] exp5;
      exp5 = W2'(W'(8'h5D)) * W2'(W'(8'hA3));
      opA = W'(8'h5D); opB = W'(8'hA3); start = 1'b1;
      @(negedge clk);
      opA = W'(8'hFF); opB = W'(8'hFF);
      repeat (3) @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      check(product == exp5, "R5", product, exp5);
    end

    // R8: back-to-back from the done cycle
    runOp(W'(8'h3C), W'(8'h99), "R8 first");
    runOp(W'(8'hE1), W'(8'h7F), "R8 second");

    // R6: hold across idle gap
    begin
      logic [W2-1:0] held;
      held = product;
      repeat (6) @(negedge clk);
      check(product == held, "R6 hold", product, held);
    end

    // R4: random operands, mixed gaps
    for (int i = 0; i < 300; i++) begin
      runOp(W'($urandom), W'($urandom), "R4 random");
      if ($urandom_range(0, 2) != 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule